// File: doc/BRIEF.md
# PHY Status-Change Interrupt Controller

This block sits beside a multi-condition physical-layer status source and turns changes in that status into one active-low interrupt pin. Four level inputs are watched: link state, duplex mode, auto-negotiation state and a medium attachment fault. Every transition of an input, in either direction, sets a sticky flag. Each flag has its own enable, and both sit in one event register that a simple request/write/address port reaches. Reading that register returns the flags and clears them. A change that arrives in the same cycle as the read survives the clear.

A control register holds a global interrupt enable and a port-0 alternate attachment select. The interrupt pin is driven only while it is needed as an interrupt. When the global enable is off and port 0 uses the alternate attachment, the pin driver is released. The pin's input level is then passed on as an active-high collision indication. Status inputs may be asynchronous and pass through a parameterised synchroniser. The levels present when reset ends are taken as the baseline and are never reported as changes.

Top module: `phy_irq_ctrl`

## Requirements
- R1: After reset the pin is driven (pin_oe_o=1) and high, coll_o is 0, and every register reads as zero.
- R2: A transition in either direction on stat_i bit k sets event flag k. The bit order is link=0, duplex=1, auto-negotiation=2, fault=3. The flag stays set until the event register is read. In the event register (address 2) the flags occupy bits [3:0] and the enables bits [11:8].
- R3: The status levels present when reset is released are taken as the baseline and set no flag, even when they are non-zero.
- R4: With two synchroniser stages, the pin goes low on the fourth rising edge after the status input changes. It goes low only if the global enable is set and flag k's enable is set; otherwise it stays high.
- R5: A read of the event register returns the flags and enables on rdata_o after one rising edge. The read clears the flags, and the pin returns high on the next edge.
- R6: A flag whose change arrives in the same cycle as a read of the event register is still set after that read.
- R7: A write to the event register loads the enables. The flag bits in the written data have no effect.
- R8: Control register (address 1): bit 5 is the global enable and bit 2 selects the alternate attachment for port 0. Both are writable and readable; all other bits read zero.
- R9: Flags are recorded while the global enable or the per-flag enable is off, and the pin stays high.
- R10: When the global enable is 0 and the alternate select is 1, pin_oe_o is 0 and coll_o follows pin_i. In every other setting pin_oe_o is 1 and coll_o is 0.
- R11: Reads of unmapped addresses return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stat_i | input | NUM_COND (4) | Status levels: link, duplex, auto-negotiation, fault |
| req_i | input | 1 | Register access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W (5) | Register address |
| wdata_i | input | DATA_W (16) | Write data |
| rdata_o | output | DATA_W (16) | Read data, valid one edge after a read request |
| pin_o | output | 1 | Active-low interrupt level for the shared pin |
| pin_oe_o | output | 1 | Pin driver enable; 0 releases the pin |
| pin_i | input | 1 | Level seen on the shared pin |
| coll_o | output | 1 | Collision indication taken from the pin while released |

## Verification
The assertions assume that accesses are single-cycle pulses with a stable address and write enable. They also assume that the status inputs are sampled only through the synchroniser, so a flag follows one edge after the detector reports a change. The stimulus changes status bits and register inputs only on falling clock edges. It spaces each status change well beyond the synchroniser depth and always waits past the post-reset baseline window before the first change. The same-cycle case is timed so that the read request sits exactly on the edge where the change is detected.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;

   localparam int unsigned COND_LINK   = 0;
   localparam int unsigned COND_DUPLEX = 1;
   localparam int unsigned COND_ANEG   = 2;
   localparam int unsigned COND_FAULT  = 3;

   typedef struct packed {
      logic gie;
      logic alt;
   } ctrl_t;

   function automatic logic irq_active(input ctrl_t c, input logic [3:0] flg, input logic [3:0] ena);
      return c.gie && ((flg & ena) != 4'b0);
   endfunction

endpackage

// File: rtl/phy_irq_change_det.sv
module phy_irq_change_det #(
   parameter int unsigned N           = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] lvl_i,
   output logic [N-1:0] chg_o
);

   localparam int unsigned ARM_CNT = SYNC_STAGES + 1;
   localparam int unsigned CNT_W   = $clog2(ARM_CNT + 1);

   initial begin
      width_chk: assert (N >= 1 && N <= 16)
         else $error("phy_irq_change_det: N out of range");
      depth_chk: assert (SYNC_STAGES <= 4)
         else $error("phy_irq_change_det: SYNC_STAGES too large");
   end

   logic [N-1:0]     lvl_s;
   logic [N-1:0]     prev_q;
   logic [CNT_W-1:0] arm_cnt_q;
   logic             armed;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign lvl_s = lvl_i;
      end else begin : g_sync
         logic [N-1:0] pipe_q [SYNC_STAGES];
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               for (int k = 0; k < SYNC_STAGES; k++) pipe_q[k] <= '0;
            end else begin
               pipe_q[0] <= lvl_i;
               for (int k = 1; k < SYNC_STAGES; k++) pipe_q[k] <= pipe_q[k-1];
            end
         end
         assign lvl_s = pipe_q[SYNC_STAGES-1];
      end
   endgenerate

   // baseline: the comparison register must hold a synchronised level
   // before any difference counts as a change
   assign armed = (arm_cnt_q == CNT_W'(ARM_CNT));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         arm_cnt_q <= '0;
         prev_q    <= '0;
      end else begin
         prev_q <= lvl_s;
         if (!armed) arm_cnt_q <= arm_cnt_q + 1'b1;
      end
   end

   assign chg_o = armed ? (lvl_s ^ prev_q) : '0;

endmodule

// File: rtl/phy_irq_flags.sv
module phy_irq_flags #(
   parameter int unsigned N = 4
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] chg_i,
   input  logic         clr_i,
   output logic [N-1:0] flags_o
);

   logic [N-1:0] flags_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flags_q <= '0;
      else         flags_q <= (clr_i ? '0 : flags_q) | chg_i;
   end

   assign flags_o = flags_q;

   generate
      for (genvar i = 0; i < N; i++) begin : g_chk
         // R2 R6
         chg_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            chg_i[i] |=> flags_q[i]);
         // R2
         sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (flags_q[i] && !clr_i) |=> flags_q[i]);
         // R5
         clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (clr_i && !chg_i[i]) |=> !flags_q[i]);
      end
   endgenerate

endmodule

// File: rtl/phy_irq_regs.sv
module phy_irq_regs
   import phy_irq_pkg::*;
#(
   parameter int unsigned N         = 4,
   parameter int unsigned ADDR_W    = 5,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned CTRL_ADDR = 1,
   parameter int unsigned EVT_ADDR  = 2,
   parameter int unsigned GIE_BIT   = 5,
   parameter int unsigned ALT_BIT   = 2,
   parameter int unsigned ENA_LSB   = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              req_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [N-1:0]      flags_i,
   output logic              clr_o,
   output logic [N-1:0]      ena_o,
   output ctrl_t             ctrl_o,
   output logic [DATA_W-1:0] rdata_o
);

   initial begin
      layout_chk: assert (N <= ENA_LSB && ENA_LSB + N <= DATA_W)
         else $error("phy_irq_regs: enable field does not fit");
      ctrl_bits_chk: assert (GIE_BIT < DATA_W && ALT_BIT < DATA_W && GIE_BIT != ALT_BIT)
         else $error("phy_irq_regs: control bit positions invalid");
      addr_chk: assert (CTRL_ADDR != EVT_ADDR && CTRL_ADDR < (1 << ADDR_W) && EVT_ADDR < (1 << ADDR_W))
         else $error("phy_irq_regs: register addresses invalid");
   end

   logic              hit_ctrl, hit_evt;
   logic [N-1:0]      ena_q;
   ctrl_t             ctrl_q;
   logic [DATA_W-1:0] rdata_q, rd_mux;

   assign hit_ctrl = req_i && (addr_i == ADDR_W'(CTRL_ADDR));
   assign hit_evt  = req_i && (addr_i == ADDR_W'(EVT_ADDR));
   assign clr_o    = hit_evt && !we_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ena_q  <= '0;
         ctrl_q <= '0;
      end else if (we_i) begin
         if (hit_evt) ena_q <= wdata_i[ENA_LSB +: N];
         if (hit_ctrl) begin
            ctrl_q.gie <= wdata_i[GIE_BIT];
            ctrl_q.alt <= wdata_i[ALT_BIT];
         end
      end
   end

   always_comb begin
      rd_mux = '0;
      if (hit_evt) begin
         rd_mux[N-1:0]         = flags_i;
         rd_mux[ENA_LSB +: N]  = ena_q;
      end else if (hit_ctrl) begin
         rd_mux[GIE_BIT] = ctrl_q.gie;
         rd_mux[ALT_BIT] = ctrl_q.alt;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              rdata_q <= '0;
      else if (req_i && !we_i)  rdata_q <= rd_mux;
   end

   assign ena_o   = ena_q;
   assign ctrl_o  = ctrl_q;
   assign rdata_o = rdata_q;

   // R8
   gie_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && we_i && addr_i == ADDR_W'(CTRL_ADDR)) |=> ctrl_q.gie == $past(wdata_i[GIE_BIT]));
   // R11
   unmapped_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && !we_i && !hit_ctrl && !hit_evt) |=> rdata_q == '0);
   // R11
   unmapped_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && we_i && !hit_ctrl && !hit_evt) |=> ($stable(ena_q) && $stable(ctrl_q)));

endmodule

// File: rtl/phy_irq_pin.sv
module phy_irq_pin
   import phy_irq_pkg::*;
#(
   parameter int unsigned N = 4
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  ctrl_t        ctrl_i,
   input  logic [N-1:0] flags_i,
   input  logic [N-1:0] ena_i,
   input  logic         pin_i,
   output logic         pin_o,
   output logic         pin_oe_o,
   output logic         coll_o
);

   logic irq_n_q, released, want;

   assign want     = ctrl_i.gie && ((flags_i & ena_i) != '0);
   assign released = !ctrl_i.gie && ctrl_i.alt;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_n_q <= 1'b1;
      else         irq_n_q <= !want;
   end

   assign pin_o    = irq_n_q;
   assign pin_oe_o = !released;
   assign coll_o   = released && pin_i;

   // R4
   gie_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !irq_n_q |-> $past(ctrl_i.gie));
   // R9
   masked_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((flags_i & ena_i) == '0) |=> irq_n_q);
   // R10
   coll_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pin_oe_o |-> !coll_o);

endmodule

// File: rtl/phy_irq_ctrl.sv
module phy_irq_ctrl
   import phy_irq_pkg::*;
#(
   parameter int unsigned NUM_COND    = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned CTRL_ADDR   = 1,
   parameter int unsigned EVT_ADDR    = 2,
   parameter int unsigned GIE_BIT     = 5,
   parameter int unsigned ALT_BIT     = 2,
   parameter int unsigned ENA_LSB     = 8
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [NUM_COND-1:0] stat_i,
   input  logic                req_i,
   input  logic                we_i,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic [DATA_W-1:0]   wdata_i,
   output logic [DATA_W-1:0]   rdata_o,
   output logic                pin_o,
   output logic                pin_oe_o,
   input  logic                pin_i,
   output logic                coll_o
);

   initial begin
      cond_count_chk: assert (NUM_COND == 4)
         else $error("phy_irq_ctrl: four status conditions expected");
   end

   logic [NUM_COND-1:0] chg, flags, ena;
   logic                clr;
   ctrl_t               ctrl;

   phy_irq_change_det #(.N(NUM_COND), .SYNC_STAGES(SYNC_STAGES)) u_det (
      .clk_i, .rst_ni, .lvl_i(stat_i), .chg_o(chg));

   phy_irq_flags #(.N(NUM_COND)) u_flags (
      .clk_i, .rst_ni, .chg_i(chg), .clr_i(clr), .flags_o(flags));

   phy_irq_regs #(
      .N(NUM_COND), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR),
      .EVT_ADDR(EVT_ADDR), .GIE_BIT(GIE_BIT), .ALT_BIT(ALT_BIT), .ENA_LSB(ENA_LSB)
   ) u_regs (
      .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .flags_i(flags),
      .clr_o(clr), .ena_o(ena), .ctrl_o(ctrl), .rdata_o);

   phy_irq_pin #(.N(NUM_COND)) u_pin (
      .clk_i, .rst_ni, .ctrl_i(ctrl), .flags_i(flags), .ena_i(ena),
      .pin_i, .pin_o, .pin_oe_o, .coll_o);

   // R1
   reset_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rst_ni) |-> pin_o);
   // R10
   release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!pin_oe_o) |-> (coll_o == pin_i));

endmodule

// File: tb/phy_irq_ctrl_tb.sv
module phy_irq_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  stat = 4'b1111;
   logic        req = 1'b0, we = 1'b0, pin_in = 1'b0;
   logic [4:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        pin, pin_oe, coll;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   localparam logic [4:0] A_CTRL = 5'd1, A_EVT = 5'd2;

   always #2.5 clk = ~clk;

   phy_irq_ctrl u_dut (
      .clk_i(clk), .rst_ni(rst_n), .stat_i(stat), .req_i(req), .we_i(we),
      .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pin_o(pin),
      .pin_oe_o(pin_oe), .pin_i(pin_in), .coll_o(coll));

   task automatic check(input string req_tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req_tag, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [15:0] d);
      @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
      @(negedge clk); req = 1'b0; we = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [15:0] d);
      @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
      @(negedge clk); req = 1'b0; d = rdata;
   endtask

   // flips one status bit on a falling edge, then waits four falling edges
   task automatic flip_and_wait(input int c);
      @(negedge clk); stat[c] = ~stat[c];
      repeat (4) @(negedge clk);
   endtask

   initial begin
      logic [15:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 pin", {15'b0, pin}, 16'h1);
      check("R1 oe", {15'b0, pin_oe}, 16'h1);
      check("R1 coll", {15'b0, coll}, 16'h0);
      repeat (6) @(negedge clk);
      rd(A_CTRL, v); check("R1 ctrl", v, 16'h0);
      // R3 levels held high through reset create no flags
      rd(A_EVT, v);  check("R3 baseline", v, 16'h0);

      // R8 control bits
      wr(A_CTRL, 16'hFFFF); rd(A_CTRL, v); check("R8 ctrl rd", v, 16'h0024);
      wr(A_CTRL, 16'h0020); rd(A_CTRL, v); check("R8 gie only", v, 16'h0020);

      // R2 R4 R5: every condition under every enable mask
      for (int c = 0; c < 4; c++) begin
         for (int m = 0; m < 16; m++) begin
            wr(A_EVT, 16'(m << 8));
            flip_and_wait(c);
            check($sformatf("R4 c%0d m%0h pin", c, m), {15'b0, pin}, {15'b0, ~m[c]});
            rd(A_EVT, v);
            check($sformatf("R2 R5 c%0d m%0h rd", c, m), v, 16'((m << 8) | (1 << c)));
            @(negedge clk);
            check($sformatf("R5 c%0d m%0h release", c, m), {15'b0, pin}, 16'h1);
            rd(A_EVT, v);
            check($sformatf("R5 c%0d cleared", c), v, 16'(m << 8));
         end
      end

      // R6 change on the same edge as a read
      wr(A_EVT, 16'h0F00);
      @(negedge clk); stat[2] = ~stat[2];
      @(negedge clk);
      @(negedge clk); req = 1'b1; we = 1'b0; addr = A_EVT;
      @(negedge clk); req = 1'b0; v = rdata;
      check("R6 read before", v, 16'h0F00);
      rd(A_EVT, v); check("R6 kept", v, 16'h0F04);

      // R7 flag bits in write data ignored
      wr(A_EVT, 16'h050F); rd(A_EVT, v); check("R7 write", v, 16'h0500);

      // R9 global enable off still records flags
      wr(A_CTRL, 16'h0000); wr(A_EVT, 16'h0F00);
      for (int c = 0; c < 4; c++) begin
         flip_and_wait(c);
         check($sformatf("R9 c%0d pin", c), {15'b0, pin}, 16'h1);
         rd(A_EVT, v); check($sformatf("R9 c%0d flag", c), v, 16'(16'h0F00 | (1 << c)));
      end

      // R10 pin release over all gie/alt settings and both pin levels
      for (int s = 0; s < 4; s++) begin
         wr(A_CTRL, 16'((s[1] << 5) | (s[0] << 2)));
         for (int p = 0; p < 2; p++) begin
            pin_in = p[0];
            @(negedge clk);
            check($sformatf("R10 s%0d p%0d oe", s, p), {15'b0, pin_oe}, {15'b0, !(s == 1)});
            check($sformatf("R10 s%0d p%0d coll", s, p), {15'b0, coll}, {15'b0, (s == 1) && p[0]});
         end
      end
      pin_in = 1'b0;

      // R11 unmapped addresses
      wr(A_CTRL, 16'h0020); wr(A_EVT, 16'h0300);
      for (int a = 3; a < 32; a += 7) begin
         wr(5'(a), 16'hFFFF);
         rd(5'(a), v); check($sformatf("R11 a%0d rd", a), v, 16'h0);
      end
      rd(A_CTRL, v); check("R11 ctrl kept", v, 16'h0020);
      rd(A_EVT, v);  check("R11 evt kept", v, 16'h0300);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule